// File: doc/BRIEF.md
# Triggered Readout Frame Serializer

This block turns each trigger into one fixed-length serial readout frame for a 128-channel front end. A frame has 140 byte-wide slots. The first 12 slots are a header: a sync byte, a running frame number, status bits captured when the frame starts, and zero fill. The other 128 slots hold the channels' 8-bit samples. The frame leaves on a single line, one bit per clock and most significant bit first. That makes 1120 bit periods per frame, which fits inside the mean spacing between triggers at the intended line rate.

The samples are fetched in channel order through a simple read port. The block puts a channel number on the port and raises a strobe in the cycle it takes the byte. The sample source must answer in that same cycle. A trigger that arrives during a frame is held in a small pending count, and the next frame follows the current one without a gap. When the pending count is full, a further trigger is dropped and a sticky overflow flag is raised.

Top module: `frame_serializer`

## Requirements
- R1: While reset is asserted and after reset is released, `frame_o`, `ser_o`, `busy_o` and `ovf_o` are all 0 until a trigger is sampled.
- R2: A frame occupies exactly 1120 consecutive clock cycles with `frame_o` high. Each byte slot is sent most significant bit first.
- R3: Header slot 0 is the sync byte (default 0xA5). The next CNT_W bits are the frame number and the next 8 bits are `status_i` as sampled at frame start. All remaining header bits up to bit 96 are 0.
- R4: Slots 12 to 139 carry channels 0 to 127 in order. `smp_rd_o` pulses once per channel, with `smp_addr_o` giving the channel, and the byte on `smp_data_i` in that cycle is the byte that is sent.
- R5: The first frame after reset carries number 0. Each later frame carries the previous number plus one, wrapping from all ones to 0.
- R6: Triggers that arrive during a frame are queued, up to 4 waiting. Queued frames follow with no idle cycle between them.
- R7: A trigger that arrives while 4 frames are already waiting, and no frame starts in that cycle, is dropped and sends no frame. `ovf_o` then goes to 1 and stays at 1 until reset.
- R8: `ser_o` is 0 in every cycle in which `frame_o` is 0.
- R9: `busy_o` is 1 from the cycle after any trigger is sampled until the last bit of the last queued frame, then it returns to 0.
- R10: When the block is idle, a trigger sampled at clock edge k makes `frame_o` rise after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Trigger request, one per frame |
| status_i | input | STAT_W | Status bits placed in the header at frame start |
| smp_data_i | input | SMP_W | Sample byte of the channel on `smp_addr_o` |
| smp_addr_o | output | log2(N_CH) | Channel whose sample is wanted |
| smp_rd_o | output | 1 | Strobe: sample taken this cycle |
| ser_o | output | 1 | Serial data line |
| frame_o | output | 1 | High while frame bits are on the line |
| busy_o | output | 1 | Frame running or pending |
| ovf_o | output | 1 | Sticky flag: a trigger was dropped |

## Verification
The assertions assume that `trig_i` is a clean synchronous level. Each cycle it is high counts as one trigger. They also assume that the sample source answers combinationally from `smp_addr_o`. The bench's source is a pure function of the channel and a per-phase salt, so this holds. The bench changes `status_i` and the salt only in cycles where `busy_o` is low. This keeps the expected header and payload of every frame fixed from its start to its end. Random trigger density is set so that frames queue, but the bench still returns to idle between bursts. Directed bursts push the pending count to its limit and one step past it.

// File: rtl/frame_serializer.sv
module frame_serializer #(
  parameter int N_CH      = 128,
  parameter int SMP_W     = 8,
  parameter int HDR_SLOTS = 12,
  parameter int CNT_W     = 12,
  parameter int STAT_W    = 8,
  parameter int Q_DEPTH   = 4,
  parameter logic [SMP_W-1:0] SYNC = 'hA5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trig_i,
  input  logic [STAT_W-1:0]       status_i,
  input  logic [SMP_W-1:0]        smp_data_i,
  output logic [$clog2(N_CH)-1:0] smp_addr_o,
  output logic                    smp_rd_o,
  output logic                    ser_o,
  output logic                    frame_o,
  output logic                    busy_o,
  output logic                    ovf_o
);
  localparam int SLOTS      = HDR_SLOTS + N_CH;
  localparam int FRAME_BITS = SLOTS * SMP_W;
  localparam int HDR_W      = HDR_SLOTS * SMP_W;
  localparam int PAD_W      = HDR_W - SMP_W - CNT_W - STAT_W;
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int BIT_W      = $clog2(SMP_W);
  localparam int ADDR_W     = $clog2(N_CH);
  localparam int Q_W        = $clog2(Q_DEPTH + 1);

  logic              active_q, ovf_q;
  logic [SLOT_W-1:0] slot_q;
  logic [BIT_W-1:0]  bit_q;
  logic [SMP_W-1:0]  sh_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [CNT_W-1:0]  fcnt_q;
  logic [Q_W-1:0]    pend_q;

  wire [HDR_W-1:0] hdr_new = {SYNC, fcnt_q, status_i, {PAD_W{1'b0}}};
  wire slot_end = active_q && (bit_q == BIT_W'(SMP_W - 1));
  wire last     = slot_end && (slot_q == SLOT_W'(SLOTS - 1));
  wire start    = (pend_q != '0) && (!active_q || last);
  wire in_hdr   = int'(slot_q) < HDR_SLOTS - 1;
  wire accept   = trig_i && ((pend_q != Q_W'(Q_DEPTH)) || start);

  assign smp_rd_o   = slot_end && !last && !in_hdr;
  assign smp_addr_o = ADDR_W'(int'(slot_q) - (HDR_SLOTS - 1));
  assign ser_o      = active_q & sh_q[SMP_W-1];
  assign frame_o    = active_q;
  assign busy_o     = active_q || (pend_q != '0);
  assign ovf_o      = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      hdr_q    <= '0;
      fcnt_q   <= '0;
      pend_q   <= '0;
      ovf_q    <= 1'b0;
    end else begin
      pend_q <= pend_q + Q_W'(accept) - Q_W'(start);
      if (trig_i && !accept) ovf_q <= 1'b1;
      if (start) begin
        active_q <= 1'b1;
        slot_q   <= '0;
        bit_q    <= '0;
        sh_q     <= hdr_new[HDR_W-1 -: SMP_W];
        hdr_q    <= hdr_new << SMP_W;
        fcnt_q   <= fcnt_q + 1'b1;
      end else if (last) begin
        active_q <= 1'b0;
        sh_q     <= '0;
      end else if (slot_end) begin
        slot_q <= slot_q + 1'b1;
        bit_q  <= '0;
        if (in_hdr) begin
          sh_q  <= hdr_q[HDR_W-1 -: SMP_W];
          hdr_q <= hdr_q << SMP_W;
        end else begin
          sh_q <= smp_data_i;
        end
      end else if (active_q) begin
        sh_q  <= sh_q << 1;
        bit_q <= bit_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/frame_serializer_chk.sv
module frame_serializer_chk #(
  parameter int FRAME_BITS = 1120
) (
  input logic clk,
  input logic rst_n,
  input logic trig_i,
  input logic smp_rd_o,
  input logic ser_o,
  input logic frame_o,
  input logic busy_o,
  input logic ovf_o
);
  localparam int CW = $clog2(FRAME_BITS);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else if (frame_o) run_q <= (run_q == CW'(FRAME_BITS - 1)) ? '0 : run_q + 1'b1;
    else run_q <= '0;
  end

  assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_o) |-> (run_q == '0));
  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_o |-> !ser_o);
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
  assert_frame_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |-> busy_o);
  assert_trig_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> busy_o);
  assert_pending_starts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !frame_o) |=> frame_o);
  assert_read_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_rd_o |-> frame_o);
  assert_read_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_rd_o |=> !smp_rd_o);
endmodule

bind frame_serializer frame_serializer_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .smp_rd_o(smp_rd_o),
  .ser_o(ser_o), .frame_o(frame_o), .busy_o(busy_o), .ovf_o(ovf_o)
);

// File: tb/frame_serializer_test.sv
`timescale 1ns/1ps
module frame_serializer_test;
  localparam int NCH = 128, SW = 8, HS = 12, CW = 4, STW = 8, QD = 4;
  localparam int FB = (HS + NCH) * SW, HW = HS * SW;

  logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0;
  logic [STW-1:0] status = '0;
  logic [SW-1:0] smp_data;
  logic [6:0] smp_addr;
  logic rd, ser, frame, busy, ovf;
  int salt = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] smp_fn(int a, int s);
    return 8'(((a * 29 + s * 13) ^ (a << 2)) ^ s);
  endfunction

  assign smp_data = smp_fn(int'(smp_addr), salt);

  frame_serializer #(.N_CH(NCH), .SMP_W(SW), .HDR_SLOTS(HS), .CNT_W(CW),
                     .STAT_W(STW), .Q_DEPTH(QD)) uut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .status_i(status),
    .smp_data_i(smp_data), .smp_addr_o(smp_addr), .smp_rd_o(rd),
    .ser_o(ser), .frame_o(frame), .busy_o(busy), .ovf_o(ovf));

  int tests = 0, fails = 0;
  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  logic [FB-1:0] fv;
  int nb = 0, run = 0, last_run = 0, exp_cnt = 0, exp_addr = 0, rd_err = 0;
  int idle_err = 0, frames_done = 0;
  bit wrap_seen = 0;

  task automatic check_frame();
    logic [HW-1:0] hdr;
    int bad;
    hdr = fv[FB-1 -: HW];
    chk(hdr[HW-1 -: 8] == 8'hA5, "R3", "sync byte", hdr[HW-1 -: 8], 8'hA5);
    chk(hdr[HW-9 -: CW] == CW'(exp_cnt), "R5", "frame number", hdr[HW-9 -: CW], exp_cnt);
    chk(hdr[HW-9-CW -: 8] == status, "R3", "status field", hdr[HW-9-CW -: 8], status);
    chk(hdr[HW-17-CW:0] == '0, "R3", "header padding", hdr[HW-17-CW:0] != '0, 0);
    bad = 0;
    for (int c = 0; c < NCH; c++)
      if (fv[FB-1-HW-8*c -: 8] != smp_fn(c, salt)) bad++;
    chk(bad == 0, "R4", "channel bytes wrong", bad, 0);
    chk(exp_addr == NCH && rd_err == 0, "R4", "sample reads", exp_addr - rd_err, NCH);
    exp_addr = 0; rd_err = 0;
    if (exp_cnt == 0 && frames_done > 0) wrap_seen = 1;
    exp_cnt = (exp_cnt + 1) % (1 << CW);
    frames_done++;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (rd) begin
      if (int'(smp_addr) != exp_addr) rd_err++;
      exp_addr++;
    end
    if (frame) begin
      fv = {fv[FB-2:0], ser};
      nb++; run++;
      if (nb == FB) begin check_frame(); nb = 0; end
    end else begin
      if (ser) idle_err++;
      if (run != 0) last_run = run;
      run = 0;
      if (nb != 0) begin chk(0, "R2", "partial frame bits", nb, FB); nb = 0; end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic pulse();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!frame && !ser && !busy && !ovf, "R1", "outputs in reset", {frame, ser, busy, ovf}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!frame && !ser && !busy && !ovf, "R1", "outputs after reset", {frame, ser, busy, ovf}, 0);

    status = 8'h3C; salt = 5;
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    chk(busy, "R9", "busy after trigger", busy, 1);
    chk(!frame, "R10", "frame one edge after trigger", frame, 0);
    @(negedge clk);
    chk(frame, "R10", "frame two edges after trigger", frame, 1);
    wait_idle();
    chk(last_run == FB, "R2", "single frame length", last_run, FB);
    chk(!busy, "R9", "busy after last bit", busy, 0);

    status = 8'hC5; salt = 77;
    pulse();
    repeat (100) @(negedge clk);
    for (int i = 0; i < 3; i++) begin pulse(); repeat (5) @(negedge clk); end
    wait_idle();
    chk(last_run == 4 * FB, "R6", "queued frames back to back", last_run, 4 * FB);
    chk(!ovf, "R7", "no overflow below depth", ovf, 0);

    status = 8'h81; salt = 300;
    pulse();
    repeat (50) @(negedge clk);
    for (int i = 0; i < QD; i++) pulse();
    #1;
    chk(!ovf, "R7", "no overflow at depth", ovf, 0);
    pulse();
    #1;
    chk(ovf, "R7", "overflow beyond depth", ovf, 1);
    wait_idle();
    chk(last_run == (QD + 1) * FB, "R7", "dropped trigger sends no frame", last_run, (QD + 1) * FB);

    for (int k = 0; k < 30000; k++) begin
      @(negedge clk);
      if (!busy && ($urandom % 8) == 0) begin
        status = 8'($urandom);
        salt = int'($urandom % 1000);
      end
      trig = (($urandom % 800) == 0);
    end
    @(negedge clk) trig = 1'b0;
    wait_idle();
    chk(idle_err == 0, "R8", "line high between frames", idle_err, 0);
    chk(wrap_seen, "R5", "frame number wrapped", frames_done, 1 << CW);
    chk(ovf, "R7", "overflow stays set", ovf, 1);
    chk(!busy, "R9", "idle at end", busy, 0);
    finish_run();
  end
endmodule